// File: doc/BRIEF.md
# Branch Policy Fetch Controller

This block sequences instruction fetch for a five-stage integer pipeline. It holds the program counter and produces the fetch address each cycle. It tracks which fetch slots hold live instructions. It applies one of three static ways of handling a conditional branch that resolves in the execute stage:

- **Freeze:** fetch stops behind the branch until the outcome is known.
- **Predict-not-taken:** fetch runs on sequentially, and the wrong-path instruction is discarded if the branch is taken.
- **Delayed branch:** the single instruction after the branch always executes.

The surrounding pipeline tells the block four things: when it must stall, when the instruction sitting in the decode register is a branch, and, when a branch reaches execute, whether its source operand tested as zero and what its 16-bit word offset is. The block computes the branch target itself, from the address it recorded for that branch. It raises a kill flag whenever the instruction in the fetch/decode register must be turned into a no-op. Counting kill pulses therefore gives the branch bubbles each policy costs.

Top module: `branch_fetch_ctrl`

## Requirements
- R1: While reset is active, and at the first cycle after reset with no stall, `fetch_addr` is 0 and `kill_slot` is 0. The fetch/decode slot starts empty, so a decode-branch flag in that first cycle does not hold fetch: `fetch_valid` is 1.
- R2: With no stall, no hold and no redirect, each fetch address is the previous one plus 4, with `fetch_valid` high.
- R3: The target of a taken branch is (address of the branch + 4) + (sign-extended `ex_offset` shifted left by 2). It appears on `fetch_addr` in the cycle the branch is in execute, and negative offsets go backwards.
- R4: A branch in execute is taken only when `ex_src_zero` is 1. When it is 0, fetch continues at the next sequential address.
- R5: Freeze policy (`policy_sel` = 0): a live branch in decode makes `fetch_valid` 0 for that cycle and holds the address. In the execute cycle that follows, `kill_slot` is 1 for both taken and not-taken branches, and fetch resumes at the target or at branch + 4.
- R6: Predict-not-taken policy (`policy_sel` = 1): fetch continues past a branch. `kill_slot` pulses for exactly one cycle only when the branch is taken.
- R7: Delayed policy (`policy_sel` = 2): `kill_slot` is never asserted, and the instruction after the branch is fetched and kept before the target.
- R8: `stall` forces `fetch_valid` to 0 and holds `fetch_addr`. Fetch resumes at the same address when the stall drops.
- R9: A redirect in a stalled cycle still wins. `fetch_addr` shows the target, and the first fetch after the stall is the target.
- R10: A branch flag in execute is ignored (no redirect, no kill) when the execute slot is empty because of a kill or a stall.
- R11: `policy_sel` = 3 behaves as the freeze policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| policy_sel | input | 2 | Branch policy: 0 freeze, 1 predict-not-taken, 2 delayed, 3 freeze |
| stall | input | 1 | Hold the PC and the fetch/decode register |
| dec_is_branch | input | 1 | Instruction in the fetch/decode register is a branch |
| ex_is_branch | input | 1 | Instruction in execute is a branch |
| ex_src_zero | input | 1 | Branch source operand equals zero |
| ex_offset | input | 16 | Branch word offset, signed |
| fetch_addr | output | 32 | Instruction fetch address this cycle |
| fetch_valid | output | 1 | The fetch this cycle is accepted into the fetch/decode register |
| kill_slot | output | 1 | Turn the fetch/decode register contents into a no-op |

## Verification
The hardest case to reach from the ports is a taken branch that resolves while the front end is stalled. In that cycle the redirect must win over the stall, the held slot must be killed in place, and the target must be fetched only once the stall drops. The stimulus lines up a branch with predict-not-taken so that it reaches execute in the very cycle the stall is raised. The next cycle then asserts a branch flag again in execute, to show that the emptied execute slot is ignored. The freeze policy is also driven with a not-taken branch, so the bubble and the kill are checked even though the address never leaves the sequential path.

// File: rtl/fetch_pol_pkg.sv
package fetch_pol_pkg;
  typedef enum logic [1:0] {
    POL_FREEZE     = 2'd0,
    POL_NOT_TAKEN  = 2'd1,
    POL_DELAY_SLOT = 2'd2,
    POL_FREEZE_ALT = 2'd3
  } br_policy_e;
endpackage

// File: rtl/fc_rst_sync.sv
module fc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_int_n = sync_q[1];
endmodule

// File: rtl/fc_policy_ctrl.sv
module fc_policy_ctrl
  import fetch_pol_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] policy_sel,
  input  logic       stall,
  input  logic       dec_is_branch,
  input  logic       ifid_vld,
  input  logic       ex_is_branch,
  input  logic       idex_vld,
  input  logic       ex_src_zero,
  output logic       redirect,
  output logic       kill,
  output logic       hold,
  output logic       fetch_valid
);
  br_policy_e pol;
  logic       ex_live;
  logic       is_freeze;

  always_comb begin
    pol       = br_policy_e'(policy_sel);
    is_freeze = (pol == POL_FREEZE) || (pol == POL_FREEZE_ALT);
    ex_live   = ex_is_branch && idex_vld;
    redirect  = ex_live && ex_src_zero;
    unique case (pol)
      POL_NOT_TAKEN:  kill = ex_live && ex_src_zero;
      POL_DELAY_SLOT: kill = 1'b0;
      default:        kill = ex_live;
    endcase
    hold        = is_freeze && dec_is_branch && ifid_vld && !kill;
    fetch_valid = !stall && !hold;
  end

  // R7: the delay slot is never squashed
  p_delay_nokill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pol == POL_DELAY_SLOT) |-> !kill);
endmodule

// File: rtl/fc_slot_track.sv
module fc_slot_track #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              kill,
  input  logic              hold,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              ifid_vld,
  output logic              idex_vld,
  output logic [ADDR_W-1:0] idex_pc
);
  logic              ifid_vld_d, idex_vld_d;
  logic [ADDR_W-1:0] ifid_pc_q;
  logic              advance;

  always_comb begin
    advance    = !stall;
    ifid_vld_d = ifid_vld;
    if (advance)   ifid_vld_d = fetch_valid;
    else if (kill) ifid_vld_d = 1'b0;
    idex_vld_d = advance && ifid_vld && !kill;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifid_vld <= 1'b0;
      idex_vld <= 1'b0;
    end else begin
      ifid_vld <= ifid_vld_d;
      idex_vld <= idex_vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ifid_pc_q <= '0;
      idex_pc   <= '0;
    end else if (advance) begin
      ifid_pc_q <= fetch_addr;
      idex_pc   <= ifid_pc_q;
    end
  end

  // R5: a freeze hold leaves an empty slot behind the branch
  p_hold_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !stall) |=> !ifid_vld);

  // R10: a stalled cycle always empties the execute slot
  p_stall_empty_ex_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !idex_vld);
endmodule

// File: rtl/fc_pc_unit.sv
module fc_pc_unit #(
  parameter int          ADDR_W      = 32,
  parameter int          OFS_W       = 16,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] RESET_PC    = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  input  logic              hold,
  input  logic              redirect,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] branch_pc,
  input  logic [OFS_W-1:0]  ex_offset,
  output logic [ADDR_W-1:0] fetch_addr
);
  localparam int                SHIFT = $clog2(INSTR_BYTES);
  localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(INSTR_BYTES);
  localparam logic [ADDR_W-1:0] RST_A = ADDR_W'(RESET_PC);

  logic [ADDR_W-1:0] pc_q, pc_d;
  logic [ADDR_W-1:0] target;
  logic [ADDR_W-1:0] ofs_ext;

  always_comb begin
    ofs_ext = {{(ADDR_W-OFS_W){ex_offset[OFS_W-1]}}, ex_offset} << SHIFT;
    target  = branch_pc + STEP + ofs_ext;
    fetch_addr = redirect ? target : pc_q;
    if (redirect)           pc_d = stall ? target : target + STEP;
    else if (stall || hold) pc_d = pc_q;
    else                    pc_d = pc_q + STEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= RST_A;
    else        pc_q <= pc_d;
  end

  // R2: an accepted fetch without redirect is followed by the next word
  p_seq_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !redirect) |=> (redirect || fetch_addr == $past(fetch_addr) + STEP));

  // R8: a stall without redirect keeps the fetch address
  p_stall_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redirect) |=> (redirect || fetch_addr == $past(fetch_addr)));

  // R9: a redirect under stall is refetched once the stall is gone
  p_stall_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && redirect) |=> (redirect || fetch_addr == $past(fetch_addr)));
endmodule

// File: rtl/branch_fetch_ctrl.sv
module branch_fetch_ctrl #(
  parameter int          ADDR_W      = 32,
  parameter int          OFS_W       = 16,
  parameter int          INSTR_BYTES = 4,
  parameter logic [31:0] RESET_PC    = 32'h0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        policy_sel,
  input  logic              stall,
  input  logic              dec_is_branch,
  input  logic              ex_is_branch,
  input  logic              ex_src_zero,
  input  logic [OFS_W-1:0]  ex_offset,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_valid,
  output logic              kill_slot
);
  logic              rst_int_n;
  logic              redirect, hold, ifid_vld, idex_vld;
  logic [ADDR_W-1:0] idex_pc;

  fc_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_int_n (rst_int_n)
  );

  fc_policy_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .policy_sel    (policy_sel),
    .stall         (stall),
    .dec_is_branch (dec_is_branch),
    .ifid_vld      (ifid_vld),
    .ex_is_branch  (ex_is_branch),
    .idex_vld      (idex_vld),
    .ex_src_zero   (ex_src_zero),
    .redirect      (redirect),
    .kill          (kill_slot),
    .hold          (hold),
    .fetch_valid   (fetch_valid)
  );

  fc_slot_track #(.ADDR_W(ADDR_W)) u_track (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .stall       (stall),
    .kill        (kill_slot),
    .hold        (hold),
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .ifid_vld    (ifid_vld),
    .idex_vld    (idex_vld),
    .idex_pc     (idex_pc)
  );

  fc_pc_unit #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .INSTR_BYTES(INSTR_BYTES), .RESET_PC(RESET_PC)
  ) u_pc (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .stall       (stall),
    .hold        (hold),
    .redirect    (redirect),
    .fetch_valid (fetch_valid),
    .branch_pc   (idex_pc),
    .ex_offset   (ex_offset),
    .fetch_addr  (fetch_addr)
  );

  // R6: at most one slot is squashed per branch
  p_kill_single_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    kill_slot |=> !kill_slot);
endmodule

// File: tb/tb_branch_fetch_ctrl.sv
`timescale 1ns/100ps
module tb_branch_fetch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n, stall, dec_is_branch, ex_is_branch, ex_src_zero;
  logic [1:0]  policy_sel;
  logic [15:0] ex_offset;
  logic [31:0] fetch_addr;
  logic        fetch_valid, kill_slot;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  branch_fetch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .stall(stall),
    .dec_is_branch(dec_is_branch), .ex_is_branch(ex_is_branch),
    .ex_src_zero(ex_src_zero), .ex_offset(ex_offset),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .kill_slot(kill_slot)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk3(input string tag, input logic [31:0] a, input logic v, input logic k);
    chk({tag, " addr"}, fetch_addr, a);
    chk({tag, " valid"}, {31'd0, fetch_valid}, {31'd0, v});
    chk({tag, " kill"}, {31'd0, kill_slot}, {31'd0, k});
  endtask

  // drive one cycle's inputs at the falling edge, settle, then caller checks
  task automatic cyc(input logic st, input logic db, input logic eb, input logic z,
                     input logic [15:0] ofs);
    @(negedge clk);
    stall = st; dec_is_branch = db; ex_is_branch = eb; ex_src_zero = z; ex_offset = ofs;
    #1;
  endtask

  task automatic do_reset(input logic [1:0] pol);
    @(negedge clk);
    rst_n = 1'b0; stall = 1'b1; dec_is_branch = 1'b0; ex_is_branch = 1'b0;
    ex_src_zero = 1'b0; ex_offset = '0; policy_sel = pol;
    #1;
    chk("R1 in reset addr", fetch_addr, 32'h0);
    chk("R1 in reset kill", {31'd0, kill_slot}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset(2'd0);
    cyc(0, 1, 0, 0, 0);
    chk3("R1 first fetch, empty slot ignores decode branch", 32'h0, 1, 0);
    cyc(0, 0, 0, 0, 0);
    chk3("R1 second fetch", 32'h4, 1, 0);
  endtask

  task automatic t_seq();
    do_reset(2'd1);
    for (int i = 0; i < 5; i++) begin
      cyc(0, 0, 0, 0, 0);
      chk3("R2 sequential", 32'(i * 4), 1, 0);
    end
  endtask

  task automatic t_untaken_taken();
    do_reset(2'd1);
    cyc(0, 0, 0, 0, 0); chk3("R6 fetch branch", 32'h0, 1, 0);
    cyc(0, 1, 0, 0, 0); chk3("R6 fetch successor", 32'h4, 1, 0);
    cyc(0, 0, 1, 1, 16'd5); chk3("R3 R6 taken target and kill", 32'h18, 1, 1);
    cyc(0, 0, 1, 1, 16'd5); chk3("R10 killed slot branch ignored", 32'h1C, 1, 0);
  endtask

  task automatic t_untaken_not();
    do_reset(2'd1);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    cyc(0, 0, 1, 0, 16'd5); chk3("R4 R6 not taken no kill", 32'h8, 1, 0);
    cyc(0, 0, 0, 0, 0); chk3("R4 sequential after not taken", 32'hC, 1, 0);
  endtask

  task automatic t_delayed_taken();
    do_reset(2'd2);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0); chk3("R7 slot fetched", 32'h4, 1, 0);
    cyc(0, 0, 1, 1, 16'd6); chk3("R7 target no kill", 32'h1C, 1, 0);
    cyc(0, 0, 0, 0, 0); chk3("R7 after target", 32'h20, 1, 0);
  endtask

  task automatic t_delayed_negative();
    do_reset(2'd2);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0); chk3("R7 slot after branch at 8", 32'hC, 1, 0);
    cyc(0, 0, 1, 1, 16'hFFFD); chk3("R3 negative offset", 32'h0, 1, 0);
    cyc(0, 0, 0, 0, 0); chk3("R3 after backward target", 32'h4, 1, 0);
  endtask

  task automatic t_freeze(input logic [1:0] pol, input logic taken, input string tag);
    do_reset(pol);
    cyc(0, 0, 0, 0, 0); chk3({tag, " fetch branch"}, 32'h0, 1, 0);
    cyc(0, 1, 0, 0, 0); chk3({tag, " hold bubble"}, 32'h4, 0, 0);
    cyc(0, 0, 1, taken, 16'd2);
    chk3({tag, " resolve kill"}, taken ? 32'hC : 32'h4, 1, 1);
    cyc(0, 0, 0, 0, 0);
    chk3({tag, " resume"}, taken ? 32'h10 : 32'h8, 1, 0);
  endtask

  task automatic t_stall();
    do_reset(2'd1);
    cyc(0, 0, 0, 0, 0); chk3("R8 before stall", 32'h0, 1, 0);
    cyc(1, 0, 0, 0, 0); chk3("R8 stall 1", 32'h4, 0, 0);
    cyc(1, 0, 0, 0, 0); chk3("R8 stall 2", 32'h4, 0, 0);
    cyc(0, 0, 0, 0, 0); chk3("R8 resume", 32'h4, 1, 0);
    cyc(0, 0, 0, 0, 0); chk3("R8 after resume", 32'h8, 1, 0);
  endtask

  task automatic t_stall_redirect();
    do_reset(2'd1);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    cyc(1, 0, 1, 1, 16'd4); chk3("R9 redirect wins over stall", 32'h14, 0, 1);
    cyc(0, 0, 1, 1, 16'd4); chk3("R9 R10 target fetched, empty slot ignored", 32'h14, 1, 0);
    cyc(0, 0, 0, 0, 0); chk3("R9 after target", 32'h18, 1, 0);
  endtask

  initial begin
    rst_n = 1'b0; stall = 1'b1; policy_sel = 2'd0; dec_is_branch = 1'b0;
    ex_is_branch = 1'b0; ex_src_zero = 1'b0; ex_offset = '0;
    t_reset();
    t_seq();
    t_untaken_taken();
    t_untaken_not();
    t_delayed_taken();
    t_delayed_negative();
    t_freeze(2'd0, 1'b1, "R5 freeze taken");
    t_freeze(2'd0, 1'b0, "R5 freeze not taken");
    t_freeze(2'd3, 1'b1, "R11 code 3 as freeze");
    t_stall();
    t_stall_redirect();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule